// File: doc/BRIEF.md
# NAND Device Command Front End

This block is the device-facing front end of an 8-bit multiplexed NAND flash port. It runs on a system clock and watches the host strobes. On each rising edge of the write strobe, while the chip select is low, it takes the shared byte bus as a command, an address or a data byte. The latch-enable pins decide which one. It decodes the one-byte and two-byte command sequences and gathers the column and row address. It keeps the column pointer, a busy timer and the status byte.

On each falling edge of the read strobe it returns one of three things: a byte from the page buffer, the status byte or the identification string. Read, program and erase requests leave the block as single-cycle pulses that carry the row. Page-buffer accesses go through a column-indexed port, so the surrounding logic owns the array and the buffer storage.

Two busy indications are kept. The ready/busy pin and status bit 6 tell the host when the block accepts a new operation. Status bit 5 tells whether the array itself is still working. The two differ only after a cached program.

Top module: `nfc_cmd_front`

## Requirements
- R1: A write-strobe rise with chip select low is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and data when both are 0. With chip select high, strobe edges are ignored.
- R2: Address cycles are placed by position:
  - cycle 1 gives column bits 7:0;
  - the low four bits of cycle 2 give column bits 11:8;
  - cycles 3 and 4 give row bits 7:0 and 15:8;
  - the low two bits of cycle 5 give row bits 17:16.
  A sixth or later address cycle is ignored.
- R3: Command 00h, five address cycles and 30h produce one `req_read` pulse carrying the row. They also hold `rb_n` low for exactly T_READ cycles and set the column pointer to the collected column.
- R4: After reset the block is ready (`rb_n`=1, `io_oe`=0) and is already in read setup, so five address cycles and 30h start a read without a leading 00h.
- R5: In a program sequence, each data byte after 80h and the address is written to the buffer at the column pointer, and the pointer then advances. 10h then gives one `req_prog` pulse and T_PROG busy cycles. A 10h with no data byte since the 80h starts nothing.
- R6: Command 60h, three row cycles and D0h give one `req_erase` pulse carrying the row, and T_ERASE busy cycles.
- R7: While `rb_n` is low, only 70h, F1h and FFh are acted on. Other commands, address cycles and data cycles change nothing.
- R8: The status byte has these bits:
  - bit 7 = `wp_n`;
  - bit 6 = 1 when accepting new operations;
  - bit 5 = 1 when the array is idle;
  - bits 4:1 = 0;
  - bit 0 = 1 if `arr_fail` was high when the last array operation ended.
- R9: Each read-strobe fall in data mode returns the buffer byte at the column pointer and advances the pointer. 85h with two address cycles moves the write column. 05h with two address cycles and then E0h moves the read column.
- R10: After 90h and one address cycle, successive read strobes return C8h, DCh, 90h, 95h, 54h and then start again at C8h.
- R11: FFh, accepted even while busy, aborts the operation, clears the fail bit and holds `rb_n` low for exactly T_RST cycles.
- R12: After 70h or F1h, every read strobe returns the current status until another accepted command arrives. 00h returns the block to data output without moving the column.
- R13: With `wp_n` low, 10h, 15h and D0h confirms issue no request and start no busy period.
- R14: 15h issues `req_prog` and holds `rb_n` low for T_CBSY cycles plus any remaining array time. Status bit 5 stays 0 for the full program time after `rb_n` has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; bus sampled on its rising edge |
| re_n | input | 1 | Read strobe; byte output on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus toward the block |
| io_out | output | 8 | Byte bus from the block |
| io_oe | output | 1 | Output enable for the byte bus |
| rb_n | output | 1 | Ready (1) / busy (0) |
| req_read | output | 1 | One-cycle page read request |
| req_prog | output | 1 | One-cycle page program request |
| req_erase | output | 1 | One-cycle block erase request |
| req_row | output | ROW_W | Row of the current request |
| arr_fail | input | 1 | Array failure flag, sampled when the array timer ends |
| buf_raddr | output | COL_W | Page buffer read column |
| buf_rdata | input | 8 | Page buffer byte at buf_raddr |
| buf_we | output | 1 | Page buffer write strobe |
| buf_waddr | output | COL_W | Page buffer write column |
| buf_wdata | output | 8 | Page buffer write byte |

## Verification
The column pointer is checked on the next read strobe, where a wrong value returns the wrong arithmetic buffer byte. It is also checked on the next data byte, through the buffer write address. A wrong decode state, such as a confirm accepted without data, a command taken while busy or a read that needs 00h, shows within one cycle as an extra or missing request pulse, or as an `rb_n` edge in the wrong cycle. The busy timers are checked at the exact cycle where `rb_n` must rise. Wrong status bits or a wrong output mode appear on the next read strobe, since the status byte is compared as a whole number.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_READ, SQ_PROG, SQ_ERASE, SQ_RCOL} seq_e;
  typedef enum logic [1:0] {OM_DATA, OM_STAT, OM_ID} omode_e;

  localparam logic [7:0] OP_RD_SETUP   = 8'h00;
  localparam logic [7:0] OP_RD_GO      = 8'h30;
  localparam logic [7:0] OP_PG_SETUP   = 8'h80;
  localparam logic [7:0] OP_PG_GO      = 8'h10;
  localparam logic [7:0] OP_PG_CACHE   = 8'h15;
  localparam logic [7:0] OP_ER_SETUP   = 8'h60;
  localparam logic [7:0] OP_ER_GO      = 8'hD0;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_STAT       = 8'h70;
  localparam logic [7:0] OP_STAT_ALT   = 8'hF1;
  localparam logic [7:0] OP_ABORT      = 8'hFF;
  localparam logic [7:0] OP_WCOL       = 8'h85;
  localparam logic [7:0] OP_RCOL_SETUP = 8'h05;
  localparam logic [7:0] OP_RCOL_GO    = 8'hE0;
endpackage

// File: rtl/nfc_edge.sv
module nfc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_det
    assign rise[g] = lvl[g] & ~prev[g];
    assign fall[g] = ~lvl[g] & prev[g];
  end
endmodule

// File: rtl/nfc_addr.sv
module nfc_addr #(
  parameter int COL_W = 12,
  parameter int ROW_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       start_idx,
  input  logic [2:0]       start_lim,
  input  logic             stb,
  input  logic [7:0]       din,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             col_hit
);
  localparam int COL_HI = COL_W - 8;
  localparam int ROW_HI = ROW_W - 16;

  logic [2:0] idx;
  logic [2:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= 3'd0;
      lim     <= 3'd5;
      col     <= '0;
      row     <= '0;
      col_hit <= 1'b0;
    end else begin
      col_hit <= 1'b0;
      if (start) begin
        idx <= start_idx;
        lim <= start_lim;
      end else if (stb && idx < lim) begin
        case (idx)
          3'd0: col[7:0] <= din;
          3'd1: begin
            col[COL_W-1:8] <= din[COL_HI-1:0];
            col_hit        <= 1'b1;
          end
          3'd2: row[7:0]  <= din;
          3'd3: row[15:8] <= din;
          default: row[ROW_W-1:16] <= din[ROW_HI-1:0];
        endcase
        idx <= idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/nfc_busy.sv
module nfc_busy #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] cache_val,
  input  logic [CNT_W-1:0] array_val,
  output logic [CNT_W-1:0] array_left,
  output logic             cache_busy,
  output logic             array_busy,
  output logic             array_done
);
  logic [CNT_W-1:0] cache_cnt;
  logic [CNT_W-1:0] array_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_cnt <= '0;
      array_cnt <= '0;
    end else if (load) begin
      cache_cnt <= cache_val;
      array_cnt <= array_val;
    end else begin
      if (cache_cnt != '0) cache_cnt <= cache_cnt - CNT_W'(1);
      if (array_cnt != '0) array_cnt <= array_cnt - CNT_W'(1);
    end
  end

  assign array_left = array_cnt;
  assign cache_busy = (cache_cnt != '0);
  assign array_busy = (array_cnt != '0);
  assign array_done = !load && (array_cnt == CNT_W'(1));
endmodule

// File: rtl/nfc_cmd_front.sv
module nfc_cmd_front
  import nfc_pkg::*;
#(
  parameter int COL_W   = 12,
  parameter int ROW_W   = 18,
  parameter int CNT_W   = 20,
  parameter int T_READ  = 2500,
  parameter int T_PROG  = 35000,
  parameter int T_ERASE = 350000,
  parameter int T_RST   = 500,
  parameter int T_CBSY  = 300,
  parameter int ID_LEN  = 5,
  parameter logic [8*ID_LEN-1:0] ID_BYTES = 40'hC8DC909554
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             wp_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             rb_n,
  output logic             req_read,
  output logic             req_prog,
  output logic             req_erase,
  output logic [ROW_W-1:0] req_row,
  input  logic             arr_fail,
  output logic [COL_W-1:0] buf_raddr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [COL_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata
);
  localparam int ID_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
  localparam logic [CNT_W-1:0] C_READ  = CNT_W'(T_READ);
  localparam logic [CNT_W-1:0] C_PROG  = CNT_W'(T_PROG);
  localparam logic [CNT_W-1:0] C_ERASE = CNT_W'(T_ERASE);
  localparam logic [CNT_W-1:0] C_RST   = CNT_W'(T_RST);
  localparam logic [CNT_W-1:0] C_CBSY  = CNT_W'(T_CBSY);

  // strobe edges: bit 0 write strobe, bit 1 read strobe
  logic [1:0] st_rise, st_fall;
  nfc_edge #(.N(2)) u_edge (
    .clk(clk), .rst(rst), .lvl({re_n, we_n}), .rise(st_rise), .fall(st_fall)
  );

  logic sel, ev_cmd, ev_adr, ev_dat, ev_re;
  logic cache_busy, array_busy, array_done;
  logic [CNT_W-1:0] array_left;

  assign sel    = ~ce_n;
  assign ev_cmd = st_rise[0] & sel & cle & ~ale;
  assign ev_adr = st_rise[0] & sel & ale & ~cle;
  assign ev_dat = st_rise[0] & sel & ~cle & ~ale;
  assign ev_re  = st_fall[1] & sel;

  logic cmd_ok, adr_ok, dat_ok;
  assign cmd_ok = ev_cmd & (~cache_busy | io_in == OP_STAT |
                            io_in == OP_STAT_ALT | io_in == OP_ABORT);
  assign adr_ok = ev_adr & ~cache_busy;
  assign dat_ok = ev_dat & ~cache_busy;

  seq_e             seq;
  omode_e           omode;
  logic [COL_W-1:0] col;
  logic [ID_W-1:0]  id_idx;
  logic             data_seen;
  logic             fail;

  // decode
  logic             a_start;
  logic [2:0]       a_sidx, a_lim;
  logic             b_load;
  logic [CNT_W-1:0] b_cache, b_array;
  logic             go_read, go_prog, go_erase;

  always_comb begin
    a_start = 1'b0;  a_sidx = 3'd0;  a_lim = 3'd5;
    b_load  = 1'b0;  b_cache = '0;   b_array = '0;
    go_read = 1'b0;  go_prog = 1'b0; go_erase = 1'b0;
    if (cmd_ok) begin
      case (io_in)
        OP_RD_SETUP, OP_PG_SETUP: a_start = 1'b1;
        OP_RD_GO: if (seq == SQ_READ) begin
          go_read = 1'b1; a_start = 1'b1;
          b_load  = 1'b1; b_cache = C_READ; b_array = C_READ;
        end
        OP_WCOL: if (seq == SQ_PROG) begin
          a_start = 1'b1; a_lim = 3'd2;
        end
        OP_PG_GO, OP_PG_CACHE: if (seq == SQ_PROG && data_seen && wp_n) begin
          go_prog = 1'b1;
          b_load  = 1'b1;
          b_array = array_left + C_PROG;
          b_cache = (io_in == OP_PG_CACHE) ? array_left + C_CBSY : array_left + C_PROG;
        end
        OP_ER_SETUP: begin
          a_start = 1'b1; a_sidx = 3'd2;
        end
        OP_ER_GO: if (seq == SQ_ERASE && wp_n) begin
          go_erase = 1'b1;
          b_load   = 1'b1; b_cache = C_ERASE; b_array = C_ERASE;
        end
        OP_IDENT: begin
          a_start = 1'b1; a_lim = 3'd0;
        end
        OP_RCOL_SETUP: begin
          a_start = 1'b1; a_lim = 3'd2;
        end
        OP_ABORT: begin
          b_load = 1'b1; b_cache = C_RST; b_array = C_RST;
        end
        default: ;
      endcase
    end
  end

  logic [COL_W-1:0] a_col;
  logic [ROW_W-1:0] a_row;
  logic             a_col_hit;

  nfc_addr #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
    .clk(clk), .rst(rst), .start(a_start), .start_idx(a_sidx), .start_lim(a_lim),
    .stb(adr_ok), .din(io_in), .col(a_col), .row(a_row), .col_hit(a_col_hit)
  );

  nfc_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst(rst), .load(b_load), .cache_val(b_cache), .array_val(b_array),
    .array_left(array_left), .cache_busy(cache_busy), .array_busy(array_busy),
    .array_done(array_done)
  );

  logic [7:0] status, id_byte;
  assign status  = {wp_n, ~cache_busy, ~array_busy, 4'b0000, fail};
  assign id_byte = ID_BYTES[8*(ID_LEN-1-int'(id_idx)) +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      seq       <= SQ_READ;
      omode     <= OM_DATA;
      col       <= '0;
      id_idx    <= '0;
      data_seen <= 1'b0;
      fail      <= 1'b0;
      req_read  <= 1'b0;
      req_prog  <= 1'b0;
      req_erase <= 1'b0;
      req_row   <= '0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
      io_out    <= '0;
      io_oe     <= 1'b0;
    end else begin
      req_read  <= go_read;
      req_prog  <= go_prog;
      req_erase <= go_erase;
      if (go_read | go_prog | go_erase) req_row <= a_row;
      io_oe  <= sel & ~re_n;
      buf_we <= 1'b0;

      if (b_load)                     fail <= 1'b0;
      else if (array_done & arr_fail) fail <= 1'b1;

      if (cmd_ok) begin
        case (io_in)
          OP_RD_SETUP: begin
            seq <= SQ_READ; omode <= OM_DATA;
          end
          OP_RD_GO: if (go_read) begin
            col <= a_col; omode <= OM_DATA;
          end
          OP_PG_SETUP: begin
            seq <= SQ_PROG; data_seen <= 1'b0;
          end
          OP_PG_GO, OP_PG_CACHE: if (go_prog) begin
            seq <= SQ_IDLE; data_seen <= 1'b0;
          end
          OP_ER_SETUP: seq <= SQ_ERASE;
          OP_ER_GO: if (go_erase) seq <= SQ_IDLE;
          OP_IDENT: begin
            omode <= OM_ID; id_idx <= '0; seq <= SQ_IDLE;
          end
          OP_RCOL_SETUP: seq <= SQ_RCOL;
          OP_RCOL_GO: if (seq == SQ_RCOL) begin
            col <= a_col; omode <= OM_DATA; seq <= SQ_READ;
          end
          OP_STAT, OP_STAT_ALT: omode <= OM_STAT;
          OP_ABORT: begin
            seq <= SQ_READ; omode <= OM_DATA; data_seen <= 1'b0;
          end
          default: ;
        endcase
      end else if (a_col_hit && seq == SQ_PROG) begin
        col <= a_col;
      end else if (dat_ok && seq == SQ_PROG) begin
        buf_we    <= 1'b1;
        buf_waddr <= col;
        buf_wdata <= io_in;
        col       <= col + COL_W'(1);
        data_seen <= 1'b1;
      end else if (ev_re) begin
        case (omode)
          OM_DATA: begin
            io_out <= buf_rdata;
            col    <= col + COL_W'(1);
          end
          OM_STAT: io_out <= status;
          default: begin
            io_out <= id_byte;
            id_idx <= (id_idx == ID_W'(ID_LEN-1)) ? '0 : id_idx + ID_W'(1);
          end
        endcase
      end
    end
  end

  assign rb_n      = ~cache_busy;
  assign buf_raddr = col;
endmodule

// File: rtl/nfc_cmd_front_chk.sv
module nfc_cmd_front_chk (
  input logic clk,
  input logic rst,
  input logic wp_n,
  input logic rb_n,
  input logic req_read,
  input logic req_prog,
  input logic req_erase,
  input logic buf_we
);
  // R1: one classified command issues at most one request
  assert_one_req_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_read, req_prog, req_erase}));

  // R3: a read request coincides with the busy period
  assert_read_busy_R3: assert property (@(posedge clk) disable iff (rst)
    req_read |-> !rb_n);

  // R5: program requests enter busy; buffer writes only when ready
  assert_prog_busy_R5: assert property (@(posedge clk) disable iff (rst)
    req_prog |-> !rb_n);
  assert_write_ready_R5: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(rb_n));

  // R6: erase requests enter busy
  assert_erase_busy_R6: assert property (@(posedge clk) disable iff (rst)
    req_erase |-> !rb_n);

  // R7: no new array request while already busy
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!rb_n && !$past(rb_n)) |-> !(req_read || req_prog || req_erase));

  // R13: protected writes issue nothing
  assert_wp_block_R13: assert property (@(posedge clk) disable iff (rst)
    !$past(wp_n) |-> !(req_prog || req_erase));
endmodule

bind nfc_cmd_front nfc_cmd_front_chk i_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .rb_n(rb_n), .req_read(req_read),
  .req_prog(req_prog), .req_erase(req_erase), .buf_we(buf_we)
);

// File: tb/test_nfc_cmd_front.sv
module test_nfc_cmd_front;
  localparam int COL_W = 12, ROW_W = 18, CNT_W = 8;
  localparam int TR = 6, TP = 20, TE = 14, TRS = 4, TC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb_n, req_read, req_prog, req_erase, arr_fail = 1'b0;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] buf_raddr, buf_waddr;
  logic [7:0] buf_rdata, buf_wdata;
  logic buf_we;

  always #5 clk = ~clk;

  assign buf_rdata = buf_raddr[7:0] ^ 8'hA5;

  nfc_cmd_front #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .T_READ(TR), .T_PROG(TP),
    .T_ERASE(TE), .T_RST(TRS), .T_CBSY(TC)
  ) i_nfc_cmd_front (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rb_n(rb_n), .req_read(req_read), .req_prog(req_prog), .req_erase(req_erase),
    .req_row(req_row), .arr_fail(arr_fail), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata)
  );

  int n_vec = 0, n_bad = 0;
  int n_rd = 0, n_pr = 0, n_er = 0, n_we = 0;
  logic [ROW_W-1:0] row_seen = '0;
  logic [COL_W-1:0] wa_seen = '0;
  logic [7:0] wd_seen = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (req_read)  begin n_rd++; row_seen = req_row; end
      if (req_prog)  begin n_pr++; row_seen = req_row; end
      if (req_erase) begin n_er++; row_seen = req_row; end
      if (buf_we)    begin n_we++; wa_seen = buf_waddr; wd_seen = buf_wdata; end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); bus(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); bus(1'b0, 1'b1, d); endtask
  task automatic din(input logic [7:0] d); bus(1'b0, 1'b0, d); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out;
    @(negedge clk); re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string r, input logic [7:0] exp);
    logic [7:0] v;
    rd(v);
    chk(r, {24'h0, v}, {24'h0, exp});
  endtask

  // called right after the command that starts a busy period of t cycles
  task automatic busy_chk(input string r, input int t);
    repeat (t - 2) @(negedge clk);
    chk(r, {31'h0, rb_n}, 32'h0);
    @(negedge clk);
    chk(r, {31'h0, rb_n}, 32'h1);
  endtask

  function automatic logic [7:0] bufb(input int c);
    return 8'(c) ^ 8'hA5;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset rb_n", {31'h0, rb_n}, 32'h1);
    chk("R4 reset io_oe", {31'h0, io_oe}, 32'h0);

    // R4 / R2: read with no leading setup command, extra address cycle
    adr(8'h23); adr(8'hF1); adr(8'h45); adr(8'h67); adr(8'hFE); adr(8'h99);
    cmd(8'h30);
    busy_chk("R3 read busy", TR);
    chk("R4 read count", n_rd, 1);
    chk("R2 row fields", {14'h0, row_seen}, 32'h26745);
    rd_chk("R9 first byte col 123", bufb(12'h123));
    rd_chk("R9 next byte col 124", bufb(12'h124));

    // R1: chip select high ignores a command
    ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
    rd_chk("R1 deselected command ignored", bufb(12'h125));

    // R3: full read sequence
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h01); adr(8'h00); adr(8'h00);
    cmd(8'h30);
    busy_chk("R3 read busy 2", TR);
    chk("R3 read count", n_rd, 2);
    chk("R3 read row", {14'h0, row_seen}, 32'h1);
    rd_chk("R3 col 0", bufb(0));

    // R9: random column out
    cmd(8'h05); adr(8'h10); adr(8'h00); cmd(8'hE0);
    rd_chk("R9 col out 10", bufb(8'h10));
    rd_chk("R9 col out 11", bufb(8'h11));

    // R10: identification
    cmd(8'h90); adr(8'h00);
    rd_chk("R10 id0", 8'hC8);
    rd_chk("R10 id1", 8'hDC);
    rd_chk("R10 id2", 8'h90);
    rd_chk("R10 id3", 8'h95);
    rd_chk("R10 id4", 8'h54);
    rd_chk("R10 id wrap", 8'hC8);

    // R8 / R12: status persists, 00h returns to data
    cmd(8'h70);
    rd_chk("R8 status ready", 8'hE0);
    rd_chk("R12 status again", 8'hE0);
    cmd(8'h00);
    rd_chk("R12 back to data", bufb(8'h12));

    // R5 / R9: program with column change
    cmd(8'h80); adr(8'h05); adr(8'h00); adr(8'h10); adr(8'h00); adr(8'h00);
    din(8'h3C); din(8'h3D); din(8'h3E);
    chk("R5 write count", n_we, 3);
    chk("R5 write addr", {20'h0, wa_seen}, 32'h7);
    chk("R5 write data", {24'h0, wd_seen}, 32'h3E);
    cmd(8'h85); adr(8'h40); adr(8'h00); din(8'h77);
    chk("R9 write col moved", {20'h0, wa_seen}, 32'h40);
    chk("R9 write col data", {24'h0, wd_seen}, 32'h77);
    cmd(8'h10);
    busy_chk("R5 program busy", TP);
    chk("R5 program count", n_pr, 1);
    chk("R5 program row", {14'h0, row_seen}, 32'h10);

    // R5: confirm with no data
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h03); adr(8'h00); adr(8'h00);
    cmd(8'h10);
    @(negedge clk);
    chk("R5 empty confirm no req", n_pr, 1);
    chk("R5 empty confirm ready", {31'h0, rb_n}, 32'h1);

    // R13: write protect
    wp_n = 1'b0;
    cmd(8'h60); adr(8'h40); adr(8'h00); adr(8'h00); cmd(8'hD0);
    @(negedge clk);
    chk("R13 erase refused", n_er, 0);
    chk("R13 still ready", {31'h0, rb_n}, 32'h1);
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h04); adr(8'h00); adr(8'h00);
    din(8'h01); cmd(8'h10);
    @(negedge clk);
    chk("R13 program refused", n_pr, 1);
    cmd(8'h70);
    rd_chk("R8 protect bit", 8'h60);
    wp_n = 1'b1;

    // R6 / R7: erase, busy command filtering
    cmd(8'h60); adr(8'h80); adr(8'h01); adr(8'h01); cmd(8'hD0);
    chk("R6 erase count", n_er, 1);
    chk("R6 erase row", {14'h0, row_seen}, 32'h10180);
    cmd(8'h70); cmd(8'h90);
    rd_chk("R7 status while busy", 8'h80);
    repeat (20) @(negedge clk);
    rd_chk("R7 ignored command kept status", 8'hE0);

    // R6 / R8: timed erase with failure
    arr_fail = 1'b1;
    cmd(8'h60); adr(8'h00); adr(8'h02); adr(8'h00); cmd(8'hD0);
    busy_chk("R6 erase busy", TE);
    cmd(8'h70);
    rd_chk("R8 fail bit", 8'hE1);
    arr_fail = 1'b0;

    // R11: abort during busy
    cmd(8'h60); adr(8'h00); adr(8'h03); adr(8'h00); cmd(8'hD0);
    repeat (2) @(negedge clk);
    cmd(8'hFF);
    busy_chk("R11 abort busy", TRS);
    chk("R11 erase issued", n_er, 3);
    cmd(8'h70);
    rd_chk("R11 status after abort", 8'hE0);

    // R14: cached program
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h20); adr(8'h00); adr(8'h00);
    din(8'h11);
    cmd(8'h15);
    busy_chk("R14 cache busy", TC);
    chk("R14 program req", n_pr, 2);
    cmd(8'h70);
    rd_chk("R14 array busy bit", 8'hC0);
    repeat (25) @(negedge clk);
    rd_chk("R14 array done", 8'hE0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog (all R) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule